// File: doc/BRIEF.md
# Rank Sparing Controller

This block runs on one memory board and watches the correctable-error reports for each rank on that board. One rank is held back as a spare. It is chosen once, at configuration time, as the largest rank on the board. The spare is not part of the capacity that software can address.

Each error report adds one to a saturating counter for the rank it names. When a report pushes a rank's count above a programmable threshold, the controller copies that rank into the spare, one line at a time. Each line is read from the failing rank over a dedicated copy port and then written to the spare. From then on, every access to the failing rank is sent to the spare.

Normal traffic keeps running while the copy is in progress. The combinational translation output tells the access path which rank to use:
- lines that have already been copied are served by the spare;
- reads of lines not yet copied stay on the failing rank;
- writes to lines not yet copied go to both ranks.

Only one failover can happen per board. Every board instance works on its own, and boards cannot be inserted or removed while the block is operating.

Top module: `rank_spare_ctrl`

## Requirements
- R1: A pulse on `cfgStart` loads `spareRank` with the index of the largest entry in `rankSizes`, where entry r sits at bits [r*SIZE_W +: SIZE_W]. Equal sizes resolve to the highest index. `spareValid` is set one cycle after the pulse. Any later `cfgStart` is ignored and `spareRank` never changes again.
- R2: Each `errValid` pulse adds one to the counter of rank `errRank`. The counter stops at 2^CNT_W-1. A pulse on `cntClear` zeroes every counter, and it wins over an error reported in the same cycle.
- R3: An error report starts a copy when all of these hold: the reported rank's updated count is strictly greater than `threshold`; `spareValid` is set; the rank is not the spare; and no failover has happened yet. `copyBusy` rises after the clock edge that samples the report, and `failedRank` takes the reported rank. Reports received before configuration, or reports that name the spare, never start a copy.
- R4: The copy visits lines 0 to size-1 of the failing rank in order. For each line it asserts `memRdEn` with `memRank` equal to the failing rank. When `memRdValid` returns, it asserts `memWrEn` with `memRank` equal to the spare, the same `memLine`, and the data that was read. Reads and writes never happen in the same cycle, and exactly one write is made per line.
- R5: While the copy runs, an access to the failing rank is routed as follows: a line below the copy position goes to the spare; a read of any other line stays on the failing rank; a write to any other line goes to the failing rank with `xlatDual`=1, meaning the spare must be written as well.
- R6: If a normal write hits the line that is currently being copied, the copy step for that line is abandoned and the line is read again. The copy read is held back in the cycle of that write, so the spare ends up holding the newly written data.
- R7: When the last line has been written, `copyBusy` falls and `remapDone` is set and stays set. From then on every access to `failedRank` is routed to the spare with `xlatDual`=0. Accesses to every other rank pass through unchanged at all times.
- R8: After the spare has been consumed, any further threshold crossing on a rank other than the failed rank or the spare sets `spareExhausted`, which stays set until reset. Such a crossing starts no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | One-shot pulse that selects the spare |
| rankSizes | input | NUM_RANKS*SIZE_W | Size of each rank, in lines |
| threshold | input | CNT_W | Error count that a rank must exceed |
| cntClear | input | 1 | Pulse that clears all error counters |
| errValid | input | 1 | Correctable-error report |
| errRank | input | RANK_W | Rank named by the error report |
| accValid | input | 1 | A normal access is present |
| accWrite | input | 1 | The normal access is a write |
| accRank | input | RANK_W | Rank of the normal access |
| accLine | input | SIZE_W | Line of the normal access |
| xlatRank | output | RANK_W | Rank the access path must use |
| xlatDual | output | 1 | Write must also go to the spare |
| memRdEn | output | 1 | Copy read request |
| memWrEn | output | 1 | Copy write request |
| memRank | output | RANK_W | Rank of the copy request |
| memLine | output | SIZE_W | Line of the copy request |
| memWrData | output | DATA_W | Copy write data |
| memRdValid | input | 1 | Copy read data is valid |
| memRdData | input | DATA_W | Copy read data |
| spareRank | output | RANK_W | Index of the reserved rank |
| spareValid | output | 1 | Spare has been selected |
| failedRank | output | RANK_W | Rank that was taken offline |
| copyBusy | output | 1 | Copy in progress |
| remapDone | output | 1 | Failed rank now served by the spare |
| spareExhausted | output | 1 | A crossing arrived after the spare was used |

## Verification
The following are checked on every cycle:
- copy reads only address the failing rank, and copy writes only address the spare;
- the copy port never carries a read and a write at once;
- `remapDone`, `spareExhausted` and the selected spare never change once set;
- after remap, traffic to the failed rank lands on the spare;
- ranks that are not affected always pass through.

Some behaviours can only be shown by the directed scenarios:
- that counters saturate rather than wrap;
- the tie rule for spare selection;
- that the spare's final contents equal the failing rank's data, including a line written during the copy and a line rewritten while in flight.

// File: rtl/rank_spare_pkg.sv
package rank_spare_pkg;
  typedef struct packed {
    logic loadFail;
    logic rdIssue;
    logic latch;
    logic wrIssue;
    logic advance;
    logic finish;
  } copyStrobe_t;

  typedef enum logic [1:0] {
    CP_IDLE,
    CP_READ,
    CP_WAIT,
    CP_WRITE
  } copyState_t;
endpackage

// File: rtl/rank_spare_dp.sv
module rank_spare_dp
  import rank_spare_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int SIZE_W    = 5,
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 16,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgStart,
  input  logic [NUM_RANKS*SIZE_W-1:0] rankSizes,
  input  logic [CNT_W-1:0]            threshold,
  input  logic                        cntClear,
  input  logic                        errValid,
  input  logic [RANK_W-1:0]           errRank,
  input  logic                        accValid,
  input  logic                        accWrite,
  input  logic [RANK_W-1:0]           accRank,
  input  logic [SIZE_W-1:0]           accLine,
  input  copyStrobe_t                 strb,
  input  logic [DATA_W-1:0]           memRdData,
  output logic                        trigger,
  output logic                        lastLine,
  output logic                        hazard,
  output logic [RANK_W-1:0]           xlatRank,
  output logic                        xlatDual,
  output logic [RANK_W-1:0]           memRank,
  output logic [SIZE_W-1:0]           memLine,
  output logic [DATA_W-1:0]           memWrData,
  output logic [RANK_W-1:0]           spareRank,
  output logic                        spareValid,
  output logic [RANK_W-1:0]           failedRank,
  output logic                        copyBusy,
  output logic                        remapDone,
  output logic                        spareExhausted
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  errCnt [NUM_RANKS];
  logic [CNT_W-1:0]  cntNext;
  logic [RANK_W-1:0] bestIdx, spareQ, failQ;
  logic [SIZE_W-1:0] bestSize, failSize, copyPtr;
  logic [DATA_W-1:0] dataQ;
  logic              spareValidQ, spareUsedQ, activeQ, remapQ, exhaustQ, eligible;

  // saturating per-rank error counters
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN || cntClear) errCnt[r] <= '0;
      else if (errValid && errRank == RANK_W'(r) && errCnt[r] != CNT_MAX)
        errCnt[r] <= errCnt[r] + 1'b1;
    end
  end

  assign cntNext  = (errCnt[errRank] == CNT_MAX) ? CNT_MAX : errCnt[errRank] + 1'b1;
  assign eligible = errValid && !cntClear && spareValidQ && (cntNext > threshold) &&
                    (errRank != spareQ) && !(spareUsedQ && errRank == failQ);
  assign trigger  = eligible && !spareUsedQ;

  // largest rank wins, later index wins a tie
  always_comb begin
    bestIdx  = '0;
    bestSize = rankSizes[SIZE_W-1:0];
    for (int r = 1; r < NUM_RANKS; r++) begin
      if (rankSizes[r*SIZE_W +: SIZE_W] >= bestSize) begin
        bestSize = rankSizes[r*SIZE_W +: SIZE_W];
        bestIdx  = RANK_W'(r);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spareValidQ <= 1'b0;
      spareQ      <= '0;
    end else if (cfgStart && !spareValidQ) begin
      spareValidQ <= 1'b1;
      spareQ      <= bestIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failQ      <= '0;
      spareUsedQ <= 1'b0;
      activeQ    <= 1'b0;
      remapQ     <= 1'b0;
      exhaustQ   <= 1'b0;
      copyPtr    <= '0;
      dataQ      <= '0;
    end else begin
      if (strb.loadFail) begin
        failQ      <= errRank;
        spareUsedQ <= 1'b1;
        activeQ    <= 1'b1;
        copyPtr    <= '0;
      end
      if (strb.advance) copyPtr <= copyPtr + 1'b1;
      if (strb.latch)   dataQ   <= memRdData;
      if (strb.finish) begin
        activeQ <= 1'b0;
        remapQ  <= 1'b1;
      end
      if (eligible && spareUsedQ) exhaustQ <= 1'b1;
    end
  end

  assign failSize = rankSizes[int'(failQ)*SIZE_W +: SIZE_W];
  assign lastLine = ({1'b0, copyPtr} + 1'b1) >= {1'b0, failSize};
  assign hazard   = accValid && accWrite && activeQ && accRank == failQ && accLine == copyPtr;

  // access-path translation
  always_comb begin
    xlatRank = accRank;
    xlatDual = 1'b0;
    if (spareUsedQ && accRank == failQ) begin
      if (remapQ || accLine < copyPtr) xlatRank = spareQ;
      else if (accWrite)               xlatDual = 1'b1;
    end
  end

  assign memRank        = strb.wrIssue ? spareQ : failQ;
  assign memLine        = copyPtr;
  assign memWrData      = dataQ;
  assign spareRank      = spareQ;
  assign spareValid     = spareValidQ;
  assign failedRank     = failQ;
  assign copyBusy       = activeQ;
  assign remapDone      = remapQ;
  assign spareExhausted = exhaustQ;
endmodule

// File: rtl/rank_spare_fsm.sv
module rank_spare_fsm
  import rank_spare_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic        lastLine,
  input  logic        hazard,
  input  logic        memRdValid,
  output copyStrobe_t strb
);
  copyState_t state, nextState;
  logic       redoQ;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      CP_IDLE: if (trigger) begin
        strb.loadFail = 1'b1;
        nextState     = CP_READ;
      end
      CP_READ: if (!hazard) begin
        strb.rdIssue = 1'b1;
        nextState    = CP_WAIT;
      end
      CP_WAIT: if (memRdValid) begin
        if (hazard || redoQ) nextState = CP_READ;
        else begin
          strb.latch = 1'b1;
          nextState  = CP_WRITE;
        end
      end
      CP_WRITE: if (hazard) nextState = CP_READ;
      else begin
        strb.wrIssue = 1'b1;
        if (lastLine) begin
          strb.finish = 1'b1;
          nextState   = CP_IDLE;
        end else begin
          strb.advance = 1'b1;
          nextState    = CP_READ;
        end
      end
      default: nextState = CP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= CP_IDLE;
      redoQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == CP_WAIT && !memRdValid) redoQ <= redoQ | hazard;
      else                                 redoQ <= 1'b0;
    end
  end
endmodule

// File: rtl/rank_spare_ctrl.sv
module rank_spare_ctrl
  import rank_spare_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int SIZE_W    = 5,
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 16,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgStart,
  input  logic [NUM_RANKS*SIZE_W-1:0] rankSizes,
  input  logic [CNT_W-1:0]            threshold,
  input  logic                        cntClear,
  input  logic                        errValid,
  input  logic [RANK_W-1:0]           errRank,
  input  logic                        accValid,
  input  logic                        accWrite,
  input  logic [RANK_W-1:0]           accRank,
  input  logic [SIZE_W-1:0]           accLine,
  output logic [RANK_W-1:0]           xlatRank,
  output logic                        xlatDual,
  output logic                        memRdEn,
  output logic                        memWrEn,
  output logic [RANK_W-1:0]           memRank,
  output logic [SIZE_W-1:0]           memLine,
  output logic [DATA_W-1:0]           memWrData,
  input  logic                        memRdValid,
  input  logic [DATA_W-1:0]           memRdData,
  output logic [RANK_W-1:0]           spareRank,
  output logic                        spareValid,
  output logic [RANK_W-1:0]           failedRank,
  output logic                        copyBusy,
  output logic                        remapDone,
  output logic                        spareExhausted
);
  copyStrobe_t strb;
  logic        trigger, lastLine, hazard;

  rank_spare_fsm u_fsm (
    .clk(clk), .rstN(rstN), .trigger(trigger), .lastLine(lastLine),
    .hazard(hazard), .memRdValid(memRdValid), .strb(strb)
  );

  rank_spare_dp #(
    .NUM_RANKS(NUM_RANKS), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .rankSizes(rankSizes),
    .threshold(threshold), .cntClear(cntClear), .errValid(errValid),
    .errRank(errRank), .accValid(accValid), .accWrite(accWrite),
    .accRank(accRank), .accLine(accLine), .strb(strb), .memRdData(memRdData),
    .trigger(trigger), .lastLine(lastLine), .hazard(hazard),
    .xlatRank(xlatRank), .xlatDual(xlatDual), .memRank(memRank),
    .memLine(memLine), .memWrData(memWrData), .spareRank(spareRank),
    .spareValid(spareValid), .failedRank(failedRank), .copyBusy(copyBusy),
    .remapDone(remapDone), .spareExhausted(spareExhausted)
  );

  assign memRdEn = strb.rdIssue;
  assign memWrEn = strb.wrIssue;
endmodule

// File: rtl/rank_spare_ctrl_chk.sv
module rank_spare_ctrl_chk #(
  parameter int NUM_RANKS = 4,
  parameter int SIZE_W    = 5,
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 16,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        errValid,
  input logic                        accWrite,
  input logic [RANK_W-1:0]           accRank,
  input logic [RANK_W-1:0]           xlatRank,
  input logic                        xlatDual,
  input logic                        memRdEn,
  input logic                        memWrEn,
  input logic [RANK_W-1:0]           memRank,
  input logic [RANK_W-1:0]           spareRank,
  input logic                        spareValid,
  input logic [RANK_W-1:0]           failedRank,
  input logic                        copyBusy,
  input logic                        remapDone,
  input logic                        spareExhausted
);
  // R1
  spare_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    spareValid |=> spareValid && $stable(spareRank));
  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(copyBusy) |-> $past(errValid));
  // R4
  copy_rd_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> copyBusy && memRank == failedRank);
  // R4
  copy_wr_dst_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> copyBusy && memRank == spareRank);
  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));
  // R7
  remap_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    remapDone |=> remapDone && !copyBusy);
  // R7
  remap_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remapDone && accRank == failedRank) |-> xlatRank == spareRank && !xlatDual);
  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!copyBusy && !remapDone) |-> xlatRank == accRank && !xlatDual);
  // R5
  dual_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlatDual |-> accWrite && copyBusy && accRank == failedRank);
  // R8
  exhaust_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    spareExhausted |=> spareExhausted);
endmodule

bind rank_spare_ctrl rank_spare_ctrl_chk #(
  .NUM_RANKS(NUM_RANKS), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/rank_spare_ctrl_tb.sv
module rank_spare_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4, SW = 5, CW = 8, DW = 16, RW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgStart = 1'b0;
  logic [NR*SW-1:0] rankSizes;
  logic [CW-1:0] threshold = '0;
  logic          cntClear = 1'b0, errValid = 1'b0;
  logic [RW-1:0] errRank = '0;
  logic          accValid = 1'b0, accWrite = 1'b0;
  logic [RW-1:0] accRank = '0;
  logic [SW-1:0] accLine = '0;
  logic [DW-1:0] accData = '0;
  logic [RW-1:0] xlatRank, memRank, spareRank, failedRank;
  logic          xlatDual, memRdEn, memWrEn, spareValid, copyBusy, remapDone, spareExhausted;
  logic [SW-1:0] memLine;
  logic [DW-1:0] memWrData;
  logic          memRdValid;
  logic [DW-1:0] memRdData;

  logic [DW-1:0] mem [NR][32];
  int            wrSeen;
  int            nChecks = 0, nFail = 0;
  int            hazLine = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_spare_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .rankSizes(rankSizes),
    .threshold(threshold), .cntClear(cntClear), .errValid(errValid),
    .errRank(errRank), .accValid(accValid), .accWrite(accWrite),
    .accRank(accRank), .accLine(accLine), .xlatRank(xlatRank),
    .xlatDual(xlatDual), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memRank(memRank), .memLine(memLine), .memWrData(memWrData),
    .memRdValid(memRdValid), .memRdData(memRdData), .spareRank(spareRank),
    .spareValid(spareValid), .failedRank(failedRank), .copyBusy(copyBusy),
    .remapDone(remapDone), .spareExhausted(spareExhausted)
  );

  // memory model: one-cycle copy reads, access writes follow translation
  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NR; r++)
        for (int l = 0; l < 32; l++)
          mem[r][l] <= 16'hA000 | DW'(r << 8) | DW'(l);
      memRdValid <= 1'b0;
      memRdData  <= '0;
      wrSeen     <= 0;
    end else begin
      memRdValid <= memRdEn;
      if (memRdEn) memRdData <= mem[memRank][memLine];
      if (memWrEn) begin
        mem[memRank][memLine] <= memWrData;
        wrSeen <= wrSeen + 1;
      end
      if (accValid && accWrite) begin
        mem[xlatRank][accLine] <= accData;
        if (xlatDual) mem[spareRank][accLine] <= accData;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendErr(input int rank, input int n);
    for (int i = 0; i < n; i++) begin
      errValid = 1'b1; errRank = RW'(rank);
      @(negedge clk);
    end
    errValid = 1'b0;
  endtask

  task automatic pulseClear();
    cntClear = 1'b1; @(negedge clk); cntClear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 spareValid at reset", spareValid, 0);
    chk("R3 copyBusy at reset", copyBusy, 0);
    chk("R7 remapDone at reset", remapDone, 0);
    chk("R8 spareExhausted at reset", spareExhausted, 0);
    chk("R4 memRdEn at reset", memRdEn, 0);
  endtask

  task automatic t_preconfig();
    threshold = 8'd0;
    sendErr(1, 3);
    @(negedge clk);
    chk("R3 no copy before configuration", copyBusy, 0);
    pulseClear();
  endtask

  task automatic t_config();
    rankSizes = {5'd6, 5'd12, 5'd12, 5'd8}; // r3=6 r2=12 r1=12 r0=8
    cfgStart = 1'b1; @(negedge clk); cfgStart = 1'b0;
    chk("R1 spareValid after cfg", spareValid, 1);
    chk("R1 tie picks highest index", spareRank, 2);
    rankSizes = {5'd6, 5'd12, 5'd12, 5'd20};
    cfgStart = 1'b1; @(negedge clk); cfgStart = 1'b0;
    chk("R1 second cfgStart ignored", spareRank, 2);
    rankSizes = {5'd6, 5'd12, 5'd12, 5'd8};
  endtask

  task automatic t_count();
    pulseClear();
    threshold = 8'd3;
    sendErr(0, 3);
    @(negedge clk);
    chk("R2 count equal to threshold no copy", copyBusy, 0);
    pulseClear();
    sendErr(0, 3);
    @(negedge clk);
    chk("R2 clear restarts count", copyBusy, 0);
    sendErr(2, 10);
    @(negedge clk);
    chk("R3 spare rank errors ignored", copyBusy, 0);
    pulseClear();
  endtask

  task automatic t_saturate_trigger();
    threshold = 8'd255;
    sendErr(1, 260);
    chk("R2 saturated count never exceeds max", copyBusy, 0);
    threshold = 8'd250;
    errValid = 1'b1; errRank = 2'd1;
    @(negedge clk);
    errValid = 1'b0;
    chk("R2 saturated count crosses lowered threshold", copyBusy, 1);
    chk("R3 failedRank captured", failedRank, 1);
  endtask

  task automatic t_during_copy();
    while (wrSeen < 3) @(negedge clk);
    accValid = 1'b1; accWrite = 1'b0; accRank = 2'd1; accLine = 5'd0;
    #1 chk("R5 copied line read goes to spare", xlatRank, 2);
    chk("R5 copied line no dual", xlatDual, 0);
    accLine = 5'd11;
    #1 chk("R5 uncopied read stays on failing rank", xlatRank, 1);
    accWrite = 1'b1; accData = 16'h5555;
    #1 chk("R5 uncopied write rank", xlatRank, 1);
    chk("R5 uncopied write dual", xlatDual, 1);
    accRank = 2'd0; accWrite = 1'b0;
    #1 chk("R7 other rank passes through during copy", xlatRank, 0);
    accRank = 2'd1; accWrite = 1'b1;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  task automatic t_hazard();
    while (!memRdEn) @(negedge clk);
    hazLine = int'(memLine);
    accValid = 1'b1; accWrite = 1'b1; accRank = 2'd1;
    accLine = memLine; accData = 16'h7777;
    #1 chk("R6 copy read withheld on in-flight write", memRdEn, 0);
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  task automatic t_finish();
    for (int i = 0; i < 2000 && copyBusy; i++) @(negedge clk);
    chk("R7 copy completes", copyBusy, 0);
    chk("R7 remapDone set", remapDone, 1);
    chk("R4 one write per line", wrSeen, 12);
    for (int l = 0; l < 12; l++) begin
      int exp;
      exp = 16'hA100 | l;
      if (l == 11) exp = 16'h5555;
      if (l == hazLine) exp = 16'h7777;
      chk($sformatf("R4 R6 spare line %0d", l), int'(mem[2][l]), exp);
    end
  endtask

  task automatic t_after_remap();
    accRank = 2'd1; accLine = 5'd5; accWrite = 1'b0;
    #1 chk("R7 read of failed rank goes to spare", xlatRank, 2);
    accWrite = 1'b1;
    #1 chk("R7 write of failed rank goes to spare", xlatRank, 2);
    chk("R7 no dual after remap", xlatDual, 0);
    accRank = 2'd3;
    #1 chk("R7 other rank passes through", xlatRank, 3);
    accWrite = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_exhaust();
    threshold = 8'd0;
    sendErr(1, 2);
    chk("R8 failed rank errors ignored", spareExhausted, 0);
    sendErr(0, 1);
    chk("R8 exhausted set", spareExhausted, 1);
    chk("R8 no new copy", copyBusy, 0);
    chk("R8 failedRank unchanged", failedRank, 1);
    pulseClear();
    repeat (3) @(negedge clk);
    chk("R8 exhausted sticky", spareExhausted, 1);
    chk("R8 remap kept", remapDone, 1);
  endtask

  initial begin
    rankSizes = {5'd6, 5'd12, 5'd12, 5'd8};
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_preconfig();
    t_config();
    t_count();
    t_saturate_trigger();
    t_during_copy();
    t_hazard();
    t_finish();
    t_after_remap();
    t_exhaust();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule